// File: doc/BRIEF.md
# ADC Analog Window Watchdog

This block watches the stream of conversion results from an analog-to-digital converter. It raises a sticky status flag when a result on a monitored channel lands outside a programmable window. Each conversion arrives as a one-cycle valid strobe with a channel index and a 12-bit right-aligned result. The watchdog can follow one selected channel or every converted channel. The first offending result is captured so that software can read it. An interrupt output follows the flag when its own enable bit is set.

Software programs the thresholds in the same format as the converter's output word, given by the resolution (12, 10, 8 or 6 bits) and the alignment (left or right). Bits that are not legal for that format are dropped. The result is scaled onto the 12-bit right-aligned range before the compare. While the converter reports that a conversion is running, configuration writes are ignored. The flag is cleared by writing 1 to it.

Top module: `awd_window_watchdog`

## Requirements
- R1: After reset the flag, the interrupt, the captured sample and the readback of the control (address 0) and window (address 1) registers are all zero.
- R2: A monitored result strictly above the high threshold or strictly below the low threshold sets the flag (address 2, bit 0) one clock after the valid strobe. In the same clock the result is latched into the sample register (address 3, bits 11:0).
- R3: A result equal to either threshold, or between them, does not set the flag.
- R4: In single-channel mode (control bit 1 = 0) only the channel in control bits 12:8 is monitored, and results on other channels never set the flag. A channel field of zero in this mode monitors nothing.
- R5: In all-channels mode (control bit 1 = 1) every channel is monitored and the channel field is ignored.
- R6: The flag stays set until software writes 1 to address 2 bit 0. Writing 0 has no effect. If a clear and a new out-of-window result arrive in the same cycle, the flag stays set.
- R7: The interrupt output equals the flag while the interrupt enable (control bit 2) is 1 and is 0 otherwise. Changing this enable does not change the flag.
- R8: Thresholds (address 1: low in bits 15:0, high in bits 31:16) are scaled to the 12-bit right-aligned scale from the format given by the resolution (control bits 4:3: 0 = 12, 1 = 10, 2 = 8, 3 = 6 bits) and the alignment (control bit 5, 1 = left). Right-aligned values shift left by 12 minus the resolution. Left-aligned values shift right by 4, except the 6-bit case, which shifts left by 4.
- R9: Threshold bits outside the legal mask for the current format are ignored. The masks are: right 0x0FFF/0x03FF/0x00FF/0x003F and left 0xFFF0/0xFFC0/0xFF00/0x00FC, for 12/10/8/6 bits.
- R10: Writes to the control or window register while the busy input is 1 are ignored, and their readback is unchanged.
- R11: While the flag is set, later out-of-window results do not overwrite the captured sample.
- R12: With the watchdog enable (control bit 0) at 0 the flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convValid | input | 1 | One-cycle strobe marking a new conversion result |
| convChannel | input | CH_W | Channel index of the result |
| convResult | input | 12 | Result, 12-bit right-aligned |
| convBusy | input | 1 | Conversions running; configuration writes are ignored |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| wdIrq | output | 1 | Watchdog interrupt |

## Verification
On every cycle, the embedded assertions check these properties:
- the flag stays set unless it is cleared;
- in-window results leave the flag clear;
- unselected channels and a disabled watchdog leave the flag alone;
- the captured sample holds while the flag is set;
- busy-time writes leave the configuration unchanged.

The exact threshold scaling for each resolution and alignment, the masking of illegal threshold bits, the set-over-clear priority, and the gating of the interrupt by its enable are shown only by the bench's directed scenarios and vector table.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int SAMPLE_W = 12;
  localparam int THR_W    = 16;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 2;

  typedef enum logic [1:0] {RES12 = 2'd0, RES10 = 2'd1, RES8 = 2'd2, RES6 = 2'd3} res_e;

  typedef struct packed {
    logic             enable;
    logic             allChan;
    logic             irqEn;
    res_e             res;
    logic             leftAlign;
    logic [THR_W-1:0] lowRaw;
    logic [THR_W-1:0] highRaw;
  } cfg_t;

  typedef struct packed {
    logic clrFlag;
  } strobe_t;

  function automatic logic [SAMPLE_W-1:0] toScale(input logic [THR_W-1:0] raw,
                                                  input res_e res, input logic left);
    logic [THR_W-1:0] mask;
    logic [THR_W-1:0] v;
    case ({left, res})
      {1'b0, RES12}: mask = 16'h0FFF;
      {1'b0, RES10}: mask = 16'h03FF;
      {1'b0, RES8}:  mask = 16'h00FF;
      {1'b0, RES6}:  mask = 16'h003F;
      {1'b1, RES12}: mask = 16'hFFF0;
      {1'b1, RES10}: mask = 16'hFFC0;
      {1'b1, RES8}:  mask = 16'hFF00;
      default:       mask = 16'h00FC;
    endcase
    v = raw & mask;
    if (left) v = (res == RES6) ? (v << 4) : (v >> 4);
    else      v = v << {res, 1'b0};
    return v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/awd_ctrl.sv
module awd_ctrl
  import awd_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BUS_W-1:0]    regWrData,
  input  logic                convBusy,
  input  logic                flagIn,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output cfg_t                cfg,
  output logic [CH_W-1:0]     chanSel,
  output strobe_t             strobe,
  output logic [BUS_W-1:0]    regRdData
);
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_WINDOW = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] A_SAMPLE = 2'd3;
  localparam int CH_LSB = 8;

  logic cfgWrOk;
  assign cfgWrOk = regWrEn && !convBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg     <= '0;
      chanSel <= '0;
    end else if (cfgWrOk) begin
      if (regAddr == A_CTRL) begin
        cfg.enable    <= regWrData[0];
        cfg.allChan   <= regWrData[1];
        cfg.irqEn     <= regWrData[2];
        cfg.res       <= res_e'(regWrData[4:3]);
        cfg.leftAlign <= regWrData[5];
        chanSel       <= regWrData[CH_LSB +: CH_W];
      end else if (regAddr == A_WINDOW) begin
        cfg.lowRaw  <= regWrData[THR_W-1:0];
        cfg.highRaw <= regWrData[BUS_W-1:THR_W];
      end
    end
  end

  always_comb begin
    strobe.clrFlag = regWrEn && (regAddr == A_STATUS) && regWrData[0];
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL: begin
        regRdData[0]                 = cfg.enable;
        regRdData[1]                 = cfg.allChan;
        regRdData[2]                 = cfg.irqEn;
        regRdData[4:3]               = cfg.res;
        regRdData[5]                 = cfg.leftAlign;
        regRdData[CH_LSB +: CH_W]    = chanSel;
      end
      A_WINDOW: regRdData = {cfg.highRaw, cfg.lowRaw};
      A_STATUS: regRdData[0] = flagIn;
      A_SAMPLE: regRdData[SAMPLE_W-1:0] = sampleIn;
      default:  regRdData = '0;
    endcase
  end

  AST_BUSY_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    convBusy |=> ($stable(cfg) && $stable(chanSel))) else $error("busy write changed config"); // R10
endmodule

// File: rtl/awd_datapath.sv
module awd_datapath
  import awd_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                convValid,
  input  logic [CH_W-1:0]     convChannel,
  input  logic [SAMPLE_W-1:0] convResult,
  input  cfg_t                cfg,
  input  logic [CH_W-1:0]     chanSel,
  input  strobe_t             strobe,
  output logic                flagQ,
  output logic [SAMPLE_W-1:0] sampleQ,
  output logic                irq
);
  logic [SAMPLE_W-1:0] loThr, hiThr;
  logic chanHit, monitored, outside, hit, capture;

  assign loThr     = toScale(cfg.lowRaw,  cfg.res, cfg.leftAlign);
  assign hiThr     = toScale(cfg.highRaw, cfg.res, cfg.leftAlign);
  assign chanHit   = cfg.allChan || ((chanSel != '0) && (convChannel == chanSel));
  assign monitored = convValid && cfg.enable && chanHit;
  assign outside   = (convResult > hiThr) || (convResult < loThr);
  assign hit       = monitored && outside;
  assign capture   = hit && (!flagQ || strobe.clrFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= 1'b0;
      sampleQ <= '0;
    end else begin
      if (hit)                 flagQ <= 1'b1;
      else if (strobe.clrFlag) flagQ <= 1'b0;
      if (capture)             sampleQ <= convResult;
    end
  end

  assign irq = flagQ && cfg.irqEn;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strobe.clrFlag) |=> flagQ) else $error("flag dropped"); // R6
  AST_INSIDE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && convValid && convResult >= loThr && convResult <= hiThr) |=> !flagQ)
    else $error("in-window result set flag"); // R3
  AST_OTHER_CHAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !cfg.allChan && convChannel != chanSel) |=> !flagQ)
    else $error("unselected channel set flag"); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !cfg.enable) |=> !flagQ) else $error("disabled watchdog set flag"); // R12
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strobe.clrFlag) |=> $stable(sampleQ)) else $error("sample overwritten"); // R11
endmodule

// File: rtl/awd_window_watchdog.sv
module awd_window_watchdog
  import awd_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                convValid,
  input  logic [CH_W-1:0]     convChannel,
  input  logic [SAMPLE_W-1:0] convResult,
  input  logic                convBusy,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [BUS_W-1:0]    regWrData,
  output logic [BUS_W-1:0]    regRdData,
  output logic                wdIrq
);
  cfg_t                cfg;
  strobe_t             strobe;
  logic [CH_W-1:0]     chanSel;
  logic                flag;
  logic [SAMPLE_W-1:0] sample;

  awd_ctrl #(.CH_W(CH_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .convBusy(convBusy), .flagIn(flag), .sampleIn(sample),
    .cfg(cfg), .chanSel(chanSel), .strobe(strobe), .regRdData(regRdData)
  );

  awd_datapath #(.CH_W(CH_W)) dp_i (
    .clk(clk), .rstN(rstN), .convValid(convValid), .convChannel(convChannel),
    .convResult(convResult), .cfg(cfg), .chanSel(chanSel), .strobe(strobe),
    .flagQ(flag), .sampleQ(sample), .irq(wdIrq)
  );
endmodule

// File: tb/awd_window_watchdog_tb_top.sv
`timescale 1ns/1ps
module awd_window_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convValid = 1'b0;
  logic [4:0]  convChannel = '0;
  logic [11:0] convResult = '0;
  logic        convBusy = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        wdIrq;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  awd_window_watchdog #(.CH_W(5)) dut_i (
    .clk(clk), .rstN(rstN), .convValid(convValid), .convChannel(convChannel),
    .convResult(convResult), .convBusy(convBusy), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wdIrq(wdIrq)
  );

  // {channel, result, expected flag}
  localparam logic [17:0] VEC [0:8] = '{
    {5'd3, 12'h300, 1'b0}, {5'd3, 12'h301, 1'b1}, {5'd3, 12'h100, 1'b0},
    {5'd3, 12'h0FF, 1'b1}, {5'd3, 12'h200, 1'b0}, {5'd2, 12'hFFF, 1'b0},
    {5'd4, 12'h000, 1'b0}, {5'd3, 12'hFFF, 1'b1}, {5'd3, 12'h000, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.1;
    d = regRdData;
  endtask

  task automatic conv(input logic [4:0] ch, input logic [11:0] v);
    @(negedge clk);
    convValid = 1'b1; convChannel = ch; convResult = v;
    @(negedge clk);
    convValid = 1'b0;
  endtask

  task automatic flagIs(input string tag, input logic exp);
    logic [31:0] d;
    rd(2'd2, d);
    chk(tag, d, {31'd0, exp});
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(2'd1, d); chk("R1 window", d, 32'h0);
    rd(2'd2, d); chk("R1 flag", d, 32'h0);
    rd(2'd3, d); chk("R1 sample", d, 32'h0);
    chk("R1 irq", {31'd0, wdIrq}, 32'h0);

    // Vector table: single channel 3, 12-bit right, window 0x100..0x300 (R2 R3 R4)
    wr(2'd0, 32'h0000_0305);
    wr(2'd1, 32'h0300_0100);
    foreach (VEC[i]) begin
      conv(VEC[i][17:13], VEC[i][12:1]);
      flagIs("R2/R3/R4 vector flag", VEC[i][0]);
      chk("R7 vector irq", {31'd0, wdIrq}, {31'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        rd(2'd3, d); chk("R2 captured sample", d, {20'd0, VEC[i][12:1]});
      end
      wr(2'd2, 32'h1);
    end

    // R6 sticky, write-0 ignored, R11 first sample held
    conv(5'd3, 12'hFFF);
    conv(5'd3, 12'h200);
    flagIs("R6 sticky after in-window", 1'b1);
    conv(5'd3, 12'h000);
    rd(2'd3, d); chk("R11 sample held", d, 32'hFFF);
    wr(2'd2, 32'h0);
    flagIs("R6 write 0 ignored", 1'b1);
    wr(2'd2, 32'h1);
    flagIs("R6 write 1 clears", 1'b0);
    // R6 set wins over clear in same cycle
    conv(5'd3, 12'hFFF);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd2; regWrData = 32'h1;
    convValid = 1'b1; convChannel = 5'd3; convResult = 12'h050;
    @(negedge clk);
    regWrEn = 1'b0; convValid = 1'b0;
    flagIs("R6 set wins over clear", 1'b1);
    rd(2'd3, d); chk("R11 recapture on clear cycle", d, 32'h050);
    wr(2'd2, 32'h1);

    // R7 interrupt gating
    wr(2'd0, 32'h0000_0301);
    conv(5'd3, 12'hFFF);
    flagIs("R7 flag without irq enable", 1'b1);
    chk("R7 irq masked", {31'd0, wdIrq}, 32'h0);
    wr(2'd0, 32'h0000_0305);
    chk("R7 irq after enable", {31'd0, wdIrq}, 32'h1);
    wr(2'd2, 32'h1);

    // R4 channel field zero in single mode monitors nothing
    wr(2'd0, 32'h0000_0005);
    conv(5'd0, 12'hFFF);
    flagIs("R4 channel zero monitors nothing", 1'b0);

    // R5 all channels
    wr(2'd0, 32'h0000_0307);
    conv(5'd7, 12'hFFF);
    flagIs("R5 channel 7 monitored", 1'b1);
    wr(2'd2, 32'h1);
    conv(5'd0, 12'h050);
    flagIs("R5 channel 0 monitored", 1'b1);
    wr(2'd2, 32'h1);
    conv(5'd9, 12'h200);
    flagIs("R5 in-window quiet", 1'b0);

    // R12 disabled
    wr(2'd0, 32'h0000_0304);
    conv(5'd3, 12'hFFF);
    flagIs("R12 disabled no flag", 1'b0);

    // R8 6-bit right: low 0x04 -> 0x100, high 0x30 -> 0xC00
    wr(2'd0, 32'h0000_031D);
    wr(2'd1, 32'h0030_0004);
    conv(5'd3, 12'h0FF); flagIs("R8 6-bit below low", 1'b1); wr(2'd2, 32'h1);
    conv(5'd3, 12'hC00); flagIs("R8 6-bit equal high", 1'b0);
    conv(5'd3, 12'hC01); flagIs("R8 6-bit above high", 1'b1); wr(2'd2, 32'h1);
    conv(5'd3, 12'h100); flagIs("R8 6-bit equal low", 1'b0);

    // R8/R9 8-bit left: low 0x1000 -> 0x100, high 0x80FF masked -> 0x800
    wr(2'd0, 32'h0000_0335);
    wr(2'd1, 32'h80FF_1000);
    conv(5'd3, 12'h805); flagIs("R9 illegal bits dropped", 1'b1); wr(2'd2, 32'h1);
    conv(5'd3, 12'h800); flagIs("R8 8-bit left equal high", 1'b0);
    conv(5'd3, 12'h0FF); flagIs("R8 8-bit left below low", 1'b1); wr(2'd2, 32'h1);

    // R10 writes ignored while busy
    @(negedge clk); convBusy = 1'b1;
    wr(2'd1, 32'h0FFF_0000);
    wr(2'd0, 32'h0);
    rd(2'd1, d); chk("R10 window unchanged", d, 32'h80FF_1000);
    rd(2'd0, d); chk("R10 ctrl unchanged", d, 32'h0000_0335);
    @(negedge clk); convBusy = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule